// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers five one-cycle event pulses into a status byte and exposes them to software through a single register location. Each pulse records its source in the status byte, whether or not that source is enabled. An enable mask selects which recorded sources may raise the active-high interrupt request output. Software changes the mask with set/clear writes. Bit 7 of the written byte selects the mode, and bits 4:0 select the sources.

Reading the status location returns the recorded sources together with a summary bit that mirrors the request. The same read then wipes the status and drops the request. Once the request is raised it stays high until that read, whatever happens to the mask or the sources in the meantime. A second, read-only location returns the current mask so that software can inspect it.

Top module: `evt_irq_ctrl`

## Requirements
- R1: An event pulse on `evtPulse[i]` sets status bit i on the next clock edge whether or not the source is enabled. The bit mapping is: bit 0 timer A underflow, bit 1 timer B underflow, bit 2 alarm, bit 3 serial port, bit 4 external flag.
- R2: A write at `regAddr`=0 with `wrData[7]`=1 sets every mask bit i for which `wrData[i]`=1 (i in 0..4), and leaves the other mask bits unchanged.
- R3: A write at `regAddr`=0 with `wrData[7]`=0 clears every mask bit i for which `wrData[i]`=1, and leaves the other mask bits unchanged.
- R4: A read at `regAddr`=0 returns, in the same cycle, {request, 2'b00, status[4:0]} on `rdData`. After that clock edge the status is zero and `irqReq` is low, unless R9 applies.
- R5: When status AND mask is nonzero after an edge, `irqReq` is high from that edge on.
- R6: Once `irqReq` is high it stays high until a status read. Clearing mask bits or receiving further events does not lower it.
- R7: A set-mode mask write that enables a source already pending in the status raises `irqReq` on the following edge.
- R8: A status that is pending only while masked reads back with bit 7 = 0, and the read still clears it.
- R9: An event pulse that arrives in the same cycle as a status read is kept in the status for the next read. If that source is enabled, `irqReq` is high after the edge.
- R10: After reset the status, the mask and the request are all zero. A read at `regAddr`=1 returns {3'b000, mask[4:0]}.
- R11: While `busSel` is low, reads and writes have no effect and `rdData` is 0. A write at `regAddr`=1 leaves the mask unchanged.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| evtPulse | input | 5 | One-cycle event pulses, one per source |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | Write strobe, valid with busSel |
| busRd | input | 1 | Read strobe, valid with busSel |
| regAddr | input | 1 | 0 = status read / mask write, 1 = mask readback |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational, zero when no read |
| irqReq | output | 1 | Interrupt request, active high |

## Verification
The assertions take three things for granted. The strobes and the address are stable for the whole cycle around each rising edge. A status read is a single-cycle strobe. The event pulses are plain levels sampled at the edge, so a pulse held high for several cycles counts as repeated events. The stimulus drives every input one time unit after a rising edge and holds it for exactly one cycle. It returns to idle between accesses, except in the deliberate cases of an event during a read and a bus access with `busSel` low. A behavioural model in the bench predicts the request and the read data on every clock.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
package evt_irq_pkg;

  localparam int SRC_NUM_DEF   = 5;
  localparam int DATA_W_DEF    = 8;
  localparam int REQ_BIT_DEF   = 7;
  localparam int SET_BIT_DEF   = 7;

  localparam logic ADDR_CTL   = 1'b0;
  localparam logic ADDR_MASK  = 1'b1;

  typedef struct packed {
    logic maskWr;
    logic statusRd;
    logic maskRd;
  } ctlStrobe_t;

endpackage

// File: rtl/evt_irq_seq.sv
`timescale 1ns/1ps
module evt_irq_seq
  import evt_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic       busRd,
  input  logic       regAddr,
  input  logic       hitNext,
  output ctlStrobe_t strb,
  output logic       reqQ
);

  logic reqNext;

  always_comb begin
    strb          = '0;
    strb.maskWr   = busSel && busWr && (regAddr == ADDR_CTL);
    strb.statusRd = busSel && busRd && (regAddr == ADDR_CTL);
    strb.maskRd   = busSel && busRd && (regAddr == ADDR_MASK);
  end

  // The request is only ever set by a pending enabled source; a status read
  // restarts it from whatever is still pending after the clear.
  always_comb begin
    if (strb.statusRd) reqNext = hitNext;
    else               reqNext = reqQ || hitNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqQ <= 1'b0;
    else       reqQ <= reqNext;
  end

endmodule

// File: rtl/evt_irq_path.sv
`timescale 1ns/1ps
module evt_irq_path
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC = SRC_NUM_DEF,
  parameter int DATA_W  = DATA_W_DEF,
  parameter int REQ_BIT = REQ_BIT_DEF,
  parameter int SET_BIT = SET_BIT_DEF
)(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               reqQ,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic               hitNext,
  output logic [DATA_W-1:0]  rdData
);

  logic [NUM_SRC-1:0] statusNext;
  logic [NUM_SRC-1:0] maskNext;
  logic               setMode;

  assign setMode = wrData[SET_BIT];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign maskNext[i] = !strb.maskWr ? maskQ[i] :
                         setMode      ? (maskQ[i] | wrData[i]) :
                                        (maskQ[i] & ~wrData[i]);
    // A pulse coinciding with a read survives the clear.
    assign statusNext[i] = (statusQ[i] & ~strb.statusRd) | evtPulse[i];
  end

  assign hitNext = |(statusNext & maskNext);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= statusNext;
      maskQ   <= maskNext;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.statusRd) begin
      rdData[NUM_SRC-1:0] = statusQ;
      rdData[REQ_BIT]     = reqQ;
    end else if (strb.maskRd) begin
      rdData[NUM_SRC-1:0] = maskQ;
    end
  end

  logic unusedWr;
  assign unusedWr = ^wrData;

endmodule

// File: rtl/evt_irq_ctrl.sv
`timescale 1ns/1ps
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC = SRC_NUM_DEF,
  parameter int DATA_W  = DATA_W_DEF,
  parameter int REQ_BIT = REQ_BIT_DEF,
  parameter int SET_BIT = SET_BIT_DEF
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               busSel,
  input  logic               busWr,
  input  logic               busRd,
  input  logic               regAddr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqReq
);

  ctlStrobe_t         strb;
  logic               reqQ;
  logic               hitNext;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;

  evt_irq_seq seq_i (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busRd   (busRd),
    .regAddr (regAddr),
    .hitNext (hitNext),
    .strb    (strb),
    .reqQ    (reqQ)
  );

  evt_irq_path #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .REQ_BIT (REQ_BIT),
    .SET_BIT (SET_BIT)
  ) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .evtPulse (evtPulse),
    .wrData   (wrData),
    .reqQ     (reqQ),
    .statusQ  (statusQ),
    .maskQ    (maskQ),
    .hitNext  (hitNext),
    .rdData   (rdData)
  );

  assign irqReq = reqQ;

endmodule

// File: rtl/evt_irq_chk.sv
`timescale 1ns/1ps
module evt_irq_chk #(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 8,
  parameter int REQ_BIT = 7
)(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] evtPulse,
  input logic               busSel,
  input logic               busWr,
  input logic               busRd,
  input logic               regAddr,
  input logic [DATA_W-1:0]  rdData,
  input logic               irqReq,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] maskQ
);

  logic statusRdC;
  logic ctlWrC;
  assign statusRdC = busSel && busRd && !regAddr;
  assign ctlWrC    = busSel && busWr && !regAddr;

  a_r1_evt_latched: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((statusQ & $past(evtPulse)) == $past(evtPulse)));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRdC && evtPulse == '0) |=> (statusQ == '0 && !irqReq));

  a_r4_gap_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusRdC |-> (rdData[REQ_BIT-1:NUM_SRC] == '0));

  a_r5_pending_raises: assert property (@(posedge clk) disable iff (!rstN)
    (((statusQ & maskQ) != '0) && !statusRdC) |=> irqReq);

  a_r6_req_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !statusRdC) |=> irqReq);

  a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWrC |=> $stable(maskQ));

  a_r11_idle_rd_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (rdData == '0));

endmodule

bind evt_irq_ctrl evt_irq_chk #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .REQ_BIT (REQ_BIT)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .evtPulse (evtPulse),
  .busSel   (busSel),
  .busWr    (busWr),
  .busRd    (busRd),
  .regAddr  (regAddr),
  .rdData   (rdData),
  .irqReq   (irqReq),
  .statusQ  (statusQ),
  .maskQ    (maskQ)
);

// File: tb/evt_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] evtPulse = '0;
  logic       busSel = 1'b0, busWr = 1'b0, busRd = 1'b0, regAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irqReq;

  int nChecks = 0;
  int nFails  = 0;
  string curReq = "R10";
  bit   done = 1'b0;

  // behavioural reference state
  bit [4:0] mStat = '0;
  bit [4:0] mMask = '0;
  bit       mReq  = 1'b0;

  always #5 clk = ~clk;

  evt_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .busSel(busSel),
    .busWr(busWr), .busRd(busRd), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .irqReq(irqReq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // reference model advances on the edge, from the inputs held over it
  always @(posedge clk) begin
    if (!rstN) begin
      mStat = '0; mMask = '0; mReq = 1'b0;
    end else begin
      bit rd, wr;
      bit [4:0] nm, ns;
      rd = busSel && busRd && !regAddr;
      wr = busSel && busWr && !regAddr;
      nm = mMask;
      if (wr) nm = wrData[7] ? (mMask | wrData[4:0]) : (mMask & ~wrData[4:0]);
      ns = (rd ? 5'd0 : mStat) | evtPulse;
      if (rd) mReq = ((ns & nm) != 0);
      else    mReq = mReq || ((ns & nm) != 0);
      mStat = ns; mMask = nm;
    end
  end

  // compare mid-cycle, while the inputs of this cycle are still held
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit [7:0] expRd;
      expRd = '0;
      if (busSel && busRd) expRd = regAddr ? {3'b000, mMask} : {mReq, 2'b00, mStat};
      check(curReq, "irqReq", int'(irqReq), int'(mReq));
      check(curReq, "rdData", int'(rdData), int'(expRd));
    end
  end

  task automatic drive(input bit sel, input bit wr, input bit rd, input bit adr,
                       input bit [7:0] d, input bit [4:0] ev);
    @(posedge clk); #1;
    busSel = sel; busWr = wr; busRd = rd; regAddr = adr; wrData = d; evtPulse = ev;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(0, 0, 0, 0, 8'h00, 5'h00);
  endtask

  task automatic expectRead(input string req, input bit adr, input bit [7:0] exp);
    drive(1, 0, 1, adr, 8'h00, 5'h00);
    @(negedge clk);
    check(req, "directed read", int'(rdData), int'(exp));
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R10: reset state
    curReq = "R10";
    @(negedge clk);
    check("R10", "irqReq after reset", int'(irqReq), 0);
    expectRead("R10", 1'b1, 8'h00);
    expectRead("R10", 1'b0, 8'h00);
    idle(1);

    // R1: each source latches while masked, no request
    curReq = "R1";
    for (int i = 0; i < 5; i++) begin
      drive(0, 0, 0, 0, 8'h00, 5'(1 << i));
      idle(1);
      check("R1", "masked irqReq", int'(irqReq), 0);
      expectRead("R1", 1'b0, 8'(1 << i));
    end
    idle(1);

    // R8: masked-only pending cleared by read, summary bit low
    curReq = "R8";
    drive(0, 0, 0, 0, 8'h00, 5'h1f);
    expectRead("R8", 1'b0, 8'h1f);
    expectRead("R8", 1'b0, 8'h00);

    // R2: set mode
    curReq = "R2";
    drive(1, 1, 0, 0, 8'h85, 5'h00);
    drive(1, 1, 0, 0, 8'h82, 5'h00);
    expectRead("R2", 1'b1, 8'h07);

    // R5: enabled event raises request
    curReq = "R5";
    drive(0, 0, 0, 0, 8'h00, 5'h04);
    idle(1);
    check("R5", "irqReq after enabled event", int'(irqReq), 1);

    // R6: request sticky through mask clear and more events
    curReq = "R6";
    drive(1, 1, 0, 0, 8'h1f, 5'h00);
    drive(0, 0, 0, 0, 8'h00, 5'h10);
    idle(2);
    check("R6", "irqReq sticky", int'(irqReq), 1);
    expectRead("R6", 1'b0, 8'h94);
    idle(1);
    check("R4", "irqReq after read", int'(irqReq), 0);

    // R3: clear mode leaves other bits
    curReq = "R3";
    drive(1, 1, 0, 0, 8'h9f, 5'h00);
    drive(1, 1, 0, 0, 8'h65, 5'h00);
    expectRead("R3", 1'b1, 8'h1a);

    // R7: enabling an already pending source
    curReq = "R7";
    drive(1, 1, 0, 0, 8'h1f, 5'h00);
    drive(0, 0, 0, 0, 8'h00, 5'h08);
    idle(1);
    check("R7", "irqReq before enable", int'(irqReq), 0);
    drive(1, 1, 0, 0, 8'h88, 5'h00);
    idle(1);
    check("R7", "irqReq after enable", int'(irqReq), 1);

    // R4 and R9: event during read is retained and re-raises
    curReq = "R9";
    drive(1, 0, 1, 0, 8'h00, 5'h08);
    @(negedge clk);
    check("R4", "read value with summary", int'(rdData), 'h88);
    idle(1);
    check("R9", "irqReq re-raised", int'(irqReq), 1);
    expectRead("R9", 1'b0, 8'h88);
    drive(1, 0, 1, 0, 8'h00, 5'h01);
    idle(1);
    check("R9", "masked retained no req", int'(irqReq), 0);
    expectRead("R9", 1'b0, 8'h01);

    // R11: deselected accesses and writes at the readback address
    curReq = "R11";
    drive(0, 1, 0, 0, 8'h9f, 5'h00);
    drive(0, 0, 1, 0, 8'h00, 5'h02);
    @(negedge clk);
    check("R11", "rdData deselected", int'(rdData), 0);
    drive(1, 1, 0, 1, 8'h9f, 5'h00);
    expectRead("R11", 1'b1, 8'h08);
    expectRead("R11", 1'b0, 8'h02);
    idle(3);
    finishRun();
  end

endmodule